// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory of 2^AW words (8K words by default). It watches the control and address inputs of both ports and produces one active-low interrupt flag per port. The two highest word addresses act as mailboxes. The lower of the two belongs to the left port and the top one belongs to the right port. When a port writes into the mailbox of the other port, the interrupt of that other port goes low. The owning port then reads its own mailbox, and that read releases the flag.

The mailbox words themselves stay ordinary storage in the array. This block never alters them, and it drives no data. If software does not use the interrupts, it can ignore the two flags and treat both words as plain memory. All inputs are sampled on one clock. Each flag is a register, so it changes on the edge that samples the qualifying access.

Top module: `mbox_irq`

## Requirements
- R1: While reset is held (rst_n low) and on the first cycle after it, both l_irq_n and r_irq_n are 1.
- R2: A right-port write sets l_irq_n to 0 on the next clock edge. A write is r_cs_n=0 and r_we_n=0 while r_busy_n=1 and r_addr equals the left mailbox 2^AW-2 (0x1FFE by default).
- R3: A left-port access releases l_irq_n to 1 on the next edge. The access needs l_cs_n=0, l_oe_n=0 and l_addr at the left mailbox, and l_we_n may be either value.
- R4: A left-port write sets r_irq_n to 0 on the next edge. It needs l_cs_n=0, l_we_n=0, l_busy_n=1 and l_addr equal to the right mailbox 2^AW-1 (0x1FFF by default).
- R5: A right-port access releases r_irq_n to 1 on the next edge. The access needs r_cs_n=0, r_oe_n=0 and r_addr at the right mailbox, and r_we_n may be either value.
- R6: A write whose own port has busy low (l_busy_n or r_busy_n = 0) leaves the opposite flag unchanged.
- R7: A set and a release of the same flag can arrive on the same edge. In that case the flag goes to 0.
- R8: Some accesses leave both flags unchanged. These are: an access with chip enable high, a read by the writer side, a write to any non-mailbox address, a port writing its own mailbox, and a release attempt with output enable high.
- R9: Both flags are always driven to a known 0 or 1 and never float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left read/write, 0 means write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_busy_n | input | 1 | Left busy, active low, blocks left-side sets |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right read/write, 0 means write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_busy_n | input | 1 | Right busy, active low, blocks right-side sets |
| l_irq_n | output | 1 | Left interrupt flag, active low |
| r_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The hardest case to reach is the collision where one port writes a mailbox on the same edge that its owner reads it. This case fixes the precedence between set and release. To reach it, the bench drives a right-side mailbox write and a left-side mailbox read in one cycle, and then does the same for the mirror case. Blocked sets are also exercised: busy is held low exactly during a qualifying write. The bench then confirms that the flag keeps its previous value, and it does so from both an idle start and a pending start.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_n,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_n,
  output logic          l_irq_n,
  output logic          r_irq_n
);

  localparam logic [AW-1:0] L_BOX = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] R_BOX = {AW{1'b1}};

  logic l_wr, r_wr, l_rd, r_rd;
  logic set_l, clr_l, set_r, clr_r;
  logic l_pend, r_pend;

  assign l_wr  = !l_cs_n && !l_we_n && l_busy_n;
  assign r_wr  = !r_cs_n && !r_we_n && r_busy_n;
  assign l_rd  = !l_cs_n && !l_oe_n;
  assign r_rd  = !r_cs_n && !r_oe_n;

  assign set_l = r_wr && (r_addr == L_BOX);
  assign clr_l = l_rd && (l_addr == L_BOX);
  assign set_r = l_wr && (l_addr == R_BOX);
  assign clr_r = r_rd && (r_addr == R_BOX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_pend <= 1'b0;
      r_pend <= 1'b0;
    end else begin
      if (set_l)      l_pend <= 1'b1;
      else if (clr_l) l_pend <= 1'b0;
      if (set_r)      r_pend <= 1'b1;
      else if (clr_r) r_pend <= 1'b0;
    end
  end

  assign l_irq_n = !l_pend;
  assign r_irq_n = !r_pend;

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs_n,
  input logic          l_we_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_n,
  input logic          r_cs_n,
  input logic          r_we_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_n,
  input logic          l_irq_n,
  input logic          r_irq_n
);

  localparam logic [AW-1:0] LB = {AW{1'b1}} - 1'b1;
  localparam logic [AW-1:0] RB = {AW{1'b1}};

  logic ls, lc, rs, rc;
  assign ls = (r_cs_n == 1'b0) && (r_we_n == 1'b0) && r_busy_n && (r_addr == LB);
  assign lc = (l_cs_n == 1'b0) && (l_oe_n == 1'b0) && (l_addr == LB);
  assign rs = (l_cs_n == 1'b0) && (l_we_n == 1'b0) && l_busy_n && (l_addr == RB);
  assign rc = (r_cs_n == 1'b0) && (r_oe_n == 1'b0) && (r_addr == RB);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));
  a_r2_set_left: assert property (@(posedge clk) disable iff (!rst_n) ls |=> !l_irq_n);
  a_r3_clear_left: assert property (@(posedge clk) disable iff (!rst_n) (lc && !ls) |=> l_irq_n);
  a_r4_set_right: assert property (@(posedge clk) disable iff (!rst_n) rs |=> !r_irq_n);
  a_r5_clear_right: assert property (@(posedge clk) disable iff (!rst_n) (rc && !rs) |=> r_irq_n);
  a_r6_hold_left: assert property (@(posedge clk) disable iff (!rst_n) (!ls && !lc) |=> $stable(l_irq_n));
  a_r8_hold_right: assert property (@(posedge clk) disable iff (!rst_n) (!rs && !rc) |=> $stable(r_irq_n));
  a_r9_driven: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown({l_irq_n, r_irq_n}));

endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbox_irq_tb.sv
`timescale 1ns/1ps
module mbox_irq_tb;
  localparam int AW = 13;
  localparam logic [AW-1:0] LB = 13'h1FFE;
  localparam logic [AW-1:0] RB = 13'h1FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_cs_n, l_we_n, l_oe_n, l_busy_n, r_cs_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbox_irq #(.AW(AW)) u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = '0; l_busy_n = 1;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = '0; r_busy_n = 1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    idle(); rst_n = 0; tick();
    chk("R1 l_irq_n in reset", l_irq_n, 1'b1);
    chk("R1 r_irq_n in reset", r_irq_n, 1'b1);
    idle(); rst_n = 1; tick();
    chk("R1 l_irq_n after reset", l_irq_n, 1'b1);
    chk("R1 r_irq_n after reset", r_irq_n, 1'b1);
  endtask

  task automatic t_left_cycle();
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = LB; tick();
    chk("R2 left set", l_irq_n, 1'b0);
    chk("R2 right untouched", r_irq_n, 1'b1);
    idle(); l_cs_n = 0; l_oe_n = 1; l_addr = LB; tick();
    chk("R8 no release with oe high", l_irq_n, 1'b0);
    idle(); l_cs_n = 0; l_oe_n = 0; l_we_n = 0; l_addr = LB; tick();
    chk("R3 release with we low", l_irq_n, 1'b1);
    chk("R8 own-box write no set", r_irq_n, 1'b1);
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = LB; tick();
    idle(); l_cs_n = 0; l_oe_n = 0; l_we_n = 1; l_addr = LB; tick();
    chk("R3 release with we high", l_irq_n, 1'b1);
  endtask

  task automatic t_right_cycle();
    idle(); l_cs_n = 0; l_we_n = 0; l_addr = RB; tick();
    chk("R4 right set", r_irq_n, 1'b0);
    chk("R4 left untouched", l_irq_n, 1'b1);
    idle(); r_cs_n = 1; r_oe_n = 0; r_addr = RB; tick();
    chk("R8 no release with cs high", r_irq_n, 1'b0);
    idle(); r_cs_n = 0; r_oe_n = 0; r_addr = RB; tick();
    chk("R5 right release", r_irq_n, 1'b1);
  endtask

  task automatic t_busy();
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = LB; r_busy_n = 0; tick();
    chk("R6 right busy blocks set", l_irq_n, 1'b1);
    idle(); l_cs_n = 0; l_we_n = 0; l_addr = RB; tick();
    idle(); l_cs_n = 0; l_we_n = 0; l_addr = RB; l_busy_n = 0; tick();
    chk("R6 busy write keeps pending", r_irq_n, 1'b0);
    idle(); r_cs_n = 0; r_oe_n = 0; r_addr = RB; tick();
    chk("R5 release after busy", r_irq_n, 1'b1);
    idle(); l_cs_n = 0; l_we_n = 0; l_addr = RB; l_busy_n = 0; tick();
    chk("R6 left busy blocks set", r_irq_n, 1'b1);
  endtask

  task automatic t_ignored();
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = 13'h1FFD; tick();
    chk("R8 non-box write", l_irq_n, 1'b1);
    idle(); r_cs_n = 0; r_oe_n = 0; r_addr = LB; tick();
    chk("R8 right read of left box", l_irq_n, 1'b1);
    idle(); r_cs_n = 1; r_we_n = 0; r_addr = LB; tick();
    chk("R8 cs high write", l_irq_n, 1'b1);
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = RB; tick();
    chk("R8 right own-box write", r_irq_n, 1'b1);
    chk("R8 right own-box write left", l_irq_n, 1'b1);
  endtask

  task automatic t_collide();
    idle(); r_cs_n = 0; r_we_n = 0; r_addr = LB;
    l_cs_n = 0; l_oe_n = 0; l_addr = LB; tick();
    chk("R7 left set beats release", l_irq_n, 1'b0);
    idle(); l_cs_n = 0; l_we_n = 0; l_addr = RB;
    r_cs_n = 0; r_oe_n = 0; r_addr = RB; tick();
    chk("R7 right set beats release", r_irq_n, 1'b0);
    chk("R9 left driven", $isunknown(l_irq_n), 1'b0);
    chk("R9 right driven", $isunknown(r_irq_n), 1'b0);
    idle(); l_cs_n = 0; l_oe_n = 0; l_addr = LB;
    r_cs_n = 0; r_oe_n = 0; r_addr = RB; tick();
    chk("R3 both release left", l_irq_n, 1'b1);
    chk("R5 both release right", r_irq_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_left_cycle();
    t_right_cycle();
    t_busy();
    t_ignored();
    t_collide();
    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule